// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block sits behind a display auxiliary-channel register window and answers I2C-over-AUX transactions aimed at a monitor's EDID, entirely in logic and within one clock. The host fills a request word into the first data register and then writes the control register with the send bit raised. The block then decodes the request. An address-only message opens, reopens or closes an EDID session. A four-byte read request fetches the next EDID byte. Any other write request is acknowledged and dropped. Every request is answered at once with a completion status in the control register and a reply word in the first data register.

EDID bytes are not stored inside the block. It presents its read pointer on `edid_idx` and takes the matching byte back on `edid_byte` in the same cycle. A per-port presence vector tells it which ports have a monitor attached.

Top module: `aux_edid_responder`

## Requirements
- R1: After reset, every register reads 0, `edid_idx` is 0 and `session_live` is 0.
- R2: Writes to the data registers at offsets 0x14, 0x18, 0x1C, 0x20 and 0x24 (low 8 address bits) are stored and read back unchanged. Any offset other than those and 0x10 reads 0, and writes to such offsets change nothing.
- R3: A write to the control register (0x10) with bit 31 clear is stored as written. It starts no transaction, so data register 1 and the session stay unchanged.
- R4: A control write with bit 31 set replaces the control register with bit 30 set, bit 31 clear, and the message-size field (bits 24:20) set to 2 for a read request or 1 for a write request. All other bits are 0. The request is read from data register 1: the I2C address is in bits 23:8, bit 28 is 1 for read, and bit 30 is the more-to-follow (MOT) flag.
- R5: A message length of 3 (control write bits 24:20) is address-only. If MOT is set and the address is 0x0050, the slave is selected and `port_id` is recorded on `session_port`. EDID is enabled only if `monitor_present[port_id]` is 1. The reply in data register 1 is 0x00000000.
- R6: An address-only message with MOT clear (stop), or with address 0, ends the session. The pointer returns to 0, the selection and enable clear, and `session_port` returns to 0.
- R7: A read request of length 4 in a live session returns the byte at the pointer as 0x00BB0000 (ACK code 0x00 in bits 31:24) and advances the pointer by one.
- R8: A read request of length 4 without a live session returns 0x00FF0000 and leaves the pointer unchanged.
- R9: The pointer stops at 128. A read request at that point returns 0x00000000 and the pointer stays at 128.
- R10: A write request (bit 28 clear) whose length is not 3 is answered with 0x00000000 in data register 1 and does not change the session.
- R11: A read request whose length is neither 3 nor 4 leaves data register 1 unchanged. The control register is still updated as in R4.
- R12: An address-only message with MOT set and an address other than 0 or 0x0050 leaves the session unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset (low byte) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset (low byte) |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| port_id | input | 2 | Port this register window belongs to |
| monitor_present | input | 4 | One bit per port, set when a monitor is attached |
| edid_byte | input | 8 | EDID byte at `edid_idx`, supplied in the same cycle |
| edid_idx | output | 8 | Current EDID read pointer |
| session_live | output | 1 | Slave selected and EDID enabled |
| session_port | output | 2 | Port recorded at selection |

## Verification
A behavioural model in the bench tracks the registers and the session, and is compared every clock against the pointer, the live flag and the port. The register file is read back after each request. Requests cover four cases: reads before any selection (0xFF filler), selection on a port with and without a monitor (so enable is kept apart from selection), a run of reads past 128 bytes (advance versus saturation), and malformed lengths for both read and write (to tell the untouched reply from the ACK-only reply). Stop, address-0 and foreign-address messages are interleaved with these to separate the two ways a session ends from the case where nothing changes.

// File: rtl/aux_edid_pkg.sv
// Shared types and helpers for the I2C-over-AUX EDID responder.
// Assumes the register window is decoded on the low 8 address bits.
package aux_edid_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_D1   = 3'd1,
        SEL_D2   = 3'd2,
        SEL_D3   = 3'd3,
        SEL_D4   = 3'd4,
        SEL_D5   = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        REQ_ADDR_ONLY = 2'd0,
        REQ_WRITE     = 2'd1,
        REQ_READ      = 2'd2,
        REQ_READ_BAD  = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [15:0] i2c_addr;
        logic        mot;
        logic        is_read;
    } req_word_t;

    // Request word field positions (decoded by the remote end, so fixed).
    localparam int ADDR_LSB    = 8;
    localparam int OP_READ_BIT = 28;
    localparam int OP_MOT_BIT  = 30;

    // Map a low-byte offset to a register selector.
    function automatic reg_sel_e map_offset(input logic [7:0] off);
        case (off)
            8'h10:   return SEL_CTRL;
            8'h14:   return SEL_D1;
            8'h18:   return SEL_D2;
            8'h1C:   return SEL_D3;
            8'h20:   return SEL_D4;
            8'h24:   return SEL_D5;
            default: return SEL_NONE;
        endcase
    endfunction

    // Pull the request fields out of data register 1.
    function automatic req_word_t split_request(input logic [31:0] w);
        req_word_t r;
        r.i2c_addr = w[ADDR_LSB +: 16];
        r.mot      = w[OP_MOT_BIT];
        r.is_read  = w[OP_READ_BIT];
        return r;
    endfunction

endpackage

// File: rtl/aux_req_parse.sv
// Request classifier: spots a control write with the send bit set and
// sorts the pending request into address-only, write, read or bad read.
// Purely combinational; assumes the request word is already in data reg 1.
module aux_req_parse
    import aux_edid_pkg::*;
#(
    parameter int SIZE_LSB = 20,
    parameter int SIZE_W   = 5,
    parameter int BUSY_BIT = 31
) (
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [31:0] req_q,
    output logic        txn_go,
    output req_kind_e   req_kind,
    output req_word_t   req
);

    localparam logic [SIZE_W-1:0] LEN_ADDR_ONLY = SIZE_W'(3);
    localparam logic [SIZE_W-1:0] LEN_READ      = SIZE_W'(4);

    logic [SIZE_W-1:0] msg_len;

    // Detect a transaction start and extract the message length.
    always_comb begin
        msg_len = wr_data[SIZE_LSB +: SIZE_W];
        txn_go  = wr_en && (map_offset(wr_addr) == SEL_CTRL) && wr_data[BUSY_BIT];
        req     = split_request(req_q);
    end

    // Classify the request by length and direction.
    always_comb begin
        if (msg_len == LEN_ADDR_ONLY)  req_kind = REQ_ADDR_ONLY;
        else if (!req.is_read)         req_kind = REQ_WRITE;
        else if (msg_len == LEN_READ)  req_kind = REQ_READ;
        else                           req_kind = REQ_READ_BAD;
    end

endmodule

// File: rtl/edid_session.sv
// EDID session tracker: slave selection, EDID enable, recorded port and a
// saturating read pointer. Supplies the reply byte for read requests.
// Assumes edid_byte is valid for edid_idx in the same cycle.
module edid_session
    import aux_edid_pkg::*;
#(
    parameter int          EDID_BYTES    = 128,
    parameter int          NPORTS        = 4,
    parameter logic [15:0] EDID_I2C_ADDR = 16'h0050,
    localparam int         PORT_W        = $clog2(NPORTS),
    localparam int         PTR_W         = $clog2(EDID_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_go,
    input  req_kind_e         req_kind,
    input  req_word_t         req,
    input  logic [PORT_W-1:0] port_id,
    input  logic [NPORTS-1:0] monitor_present,
    input  logic [7:0]        edid_byte,
    output logic              live,
    output logic [PTR_W-1:0]  ptr,
    output logic [PORT_W-1:0] port_q,
    output logic [7:0]        reply_byte
);

    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(EDID_BYTES);

    logic sel_q;
    logic avail_q;
    logic [PTR_W-1:0] ptr_q;
    logic end_session;
    logic pick_edid;

    // Decode what an address-only message does to the session.
    always_comb begin
        end_session = !req.mot || (req.i2c_addr == 16'h0000);
        pick_edid   = req.mot && (req.i2c_addr == EDID_I2C_ADDR);
    end

    // Session state update on each transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            avail_q <= 1'b0;
            ptr_q   <= '0;
            port_q  <= '0;
        end else if (txn_go) begin
            case (req_kind)
                REQ_ADDR_ONLY: begin
                    if (end_session) begin
                        sel_q   <= 1'b0;
                        avail_q <= 1'b0;
                        ptr_q   <= '0;
                        port_q  <= '0;
                    end else if (pick_edid) begin
                        sel_q  <= 1'b1;
                        port_q <= port_id;
                        if (monitor_present[port_id]) avail_q <= 1'b1;
                    end
                end
                REQ_READ: begin
                    if (sel_q && avail_q && (ptr_q < PTR_END)) ptr_q <= ptr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Reply byte: filler when no session, zero past the end, else EDID.
    always_comb begin
        live = sel_q && avail_q;
        ptr  = ptr_q;
        if (!live)                reply_byte = 8'hFF;
        else if (ptr_q >= PTR_END) reply_byte = 8'h00;
        else                      reply_byte = edid_byte;
    end

    a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END);

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> ((ptr_q == $past(ptr_q) + 1'b1) || (ptr_q == '0)));

    a_r5_avail_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        avail_q |-> sel_q);

    a_r8_idle_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> ((ptr_q == $past(ptr_q)) || (ptr_q == '0)));

endmodule

// File: rtl/aux_regfile.sv
// Control and data register file of the AUX window. Stores host writes,
// posts the completion status and the reply word on a transaction.
// Read port is combinational; unknown offsets read zero.
module aux_regfile
    import aux_edid_pkg::*;
#(
    parameter int         SIZE_LSB = 20,
    parameter int         SIZE_W   = 5,
    parameter int         DONE_BIT = 30,
    parameter int         BUSY_BIT = 31,
    parameter int         NDATA    = 5,
    parameter logic [7:0] ACK_CODE = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    input  logic        txn_go,
    input  req_kind_e   req_kind,
    input  logic        req_is_read,
    input  logic [7:0]  reply_byte,
    output logic [31:0] rd_data,
    output logic [31:0] req_q
);

    localparam logic [31:0] DONE_MASK = 32'd1 << DONE_BIT;

    logic [31:0] ctrl_q;
    logic [31:0] data_q [NDATA];
    logic [31:0] status_word;
    logic [31:0] reply_word;
    reg_sel_e    wsel;
    reg_sel_e    rsel;

    // Build the completion status and reply word.
    always_comb begin
        wsel        = map_offset(wr_addr);
        status_word = DONE_MASK | (32'(req_is_read ? 2 : 1) << SIZE_LSB);
        reply_word  = {ACK_CODE, (req_kind == REQ_READ) ? reply_byte : 8'h00, 16'h0000};
    end

    // Control register: status on a transaction, else the written value.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctrl_q <= '0;
        else if (txn_go)                          ctrl_q <= status_word;
        else if (wr_en && (wsel == SEL_CTRL))     ctrl_q <= wr_data;
    end

    // Data registers: host writes; register 1 also takes the reply.
    for (genvar i = 0; i < NDATA; i++) begin : g_data
        localparam logic [2:0] MY_SEL = 3'(i + 1);
        if (i == 0) begin : g_req
            always_ff @(posedge clk) begin
                if (!rst_n)                                      data_q[i] <= '0;
                else if (wr_en && (3'(wsel) == MY_SEL))          data_q[i] <= wr_data;
                else if (txn_go && (req_kind != REQ_READ_BAD))   data_q[i] <= reply_word;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)                                data_q[i] <= '0;
                else if (wr_en && (3'(wsel) == MY_SEL))    data_q[i] <= wr_data;
            end
        end
    end

    // Combinational read mux.
    always_comb begin
        rsel  = map_offset(rd_addr);
        req_q = data_q[0];
        case (rsel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_D1:   rd_data = data_q[0];
            SEL_D2:   rd_data = data_q[1];
            SEL_D3:   rd_data = data_q[2];
            SEL_D4:   rd_data = data_q[3];
            SEL_D5:   rd_data = data_q[4];
            default:  rd_data = '0;
        endcase
    end

    a_r4_ctrl_done: assert property (@(posedge clk) disable iff (!rst_n)
        txn_go |=> (ctrl_q[DONE_BIT] && !ctrl_q[BUSY_BIT]));

    a_r11_bad_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_go && (req_kind == REQ_READ_BAD)) |=> (data_q[0] == $past(data_q[0])));

    a_r10_write_ack_only: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_go && (req_kind == REQ_WRITE)) |=> (data_q[0] == {ACK_CODE, 24'h0}));

endmodule

// File: rtl/aux_edid_responder.sv
// Top of the I2C-over-AUX EDID responder: register window, request
// classifier and EDID session. Each request completes in one clock.
// Assumes edid_byte follows edid_idx combinationally.
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int          SIZE_LSB      = 20,
    parameter int          SIZE_W        = 5,
    parameter int          DONE_BIT      = 30,
    parameter int          BUSY_BIT      = 31,
    parameter int          NDATA         = 5,
    parameter int          EDID_BYTES    = 128,
    parameter int          NPORTS        = 4,
    parameter logic [15:0] EDID_I2C_ADDR = 16'h0050,
    parameter logic [7:0]  ACK_CODE      = 8'h00,
    localparam int         PORT_W        = $clog2(NPORTS),
    localparam int         PTR_W         = $clog2(EDID_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [PORT_W-1:0] port_id,
    input  logic [NPORTS-1:0] monitor_present,
    input  logic [7:0]        edid_byte,
    output logic [PTR_W-1:0]  edid_idx,
    output logic              session_live,
    output logic [PORT_W-1:0] session_port
);

    logic        txn_go;
    req_kind_e   req_kind;
    req_word_t   req;
    logic [31:0] req_q;
    logic [7:0]  reply_byte;

    aux_req_parse #(
        .SIZE_LSB (SIZE_LSB),
        .SIZE_W   (SIZE_W),
        .BUSY_BIT (BUSY_BIT)
    ) u_parse (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .req_q    (req_q),
        .txn_go   (txn_go),
        .req_kind (req_kind),
        .req      (req)
    );

    edid_session #(
        .EDID_BYTES    (EDID_BYTES),
        .NPORTS        (NPORTS),
        .EDID_I2C_ADDR (EDID_I2C_ADDR)
    ) u_session (
        .clk             (clk),
        .rst_n           (rst_n),
        .txn_go          (txn_go),
        .req_kind        (req_kind),
        .req             (req),
        .port_id         (port_id),
        .monitor_present (monitor_present),
        .edid_byte       (edid_byte),
        .live            (session_live),
        .ptr             (edid_idx),
        .port_q          (session_port),
        .reply_byte      (reply_byte)
    );

    aux_regfile #(
        .SIZE_LSB (SIZE_LSB),
        .SIZE_W   (SIZE_W),
        .DONE_BIT (DONE_BIT),
        .BUSY_BIT (BUSY_BIT),
        .NDATA    (NDATA),
        .ACK_CODE (ACK_CODE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .txn_go      (txn_go),
        .req_kind    (req_kind),
        .req_is_read (req.is_read),
        .reply_byte  (reply_byte),
        .rd_data     (rd_data),
        .req_q       (req_q)
    );

endmodule

// File: tb/aux_edid_responder_test.sv
`timescale 1ns/1ps
module aux_edid_responder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  port_id = '0;
    logic [3:0]  monitor_present = 4'b0100;
    logic [7:0]  edid_byte;
    logic [7:0]  edid_idx;
    logic        session_live;
    logic [1:0]  session_port;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] m_ctrl;
    logic [31:0] m_d [5];
    bit          m_sel, m_avail;
    int          m_ptr, m_port;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] edid_at(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    assign edid_byte = edid_at(int'(edid_idx));

    aux_edid_responder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .port_id(port_id),
        .monitor_present(monitor_present), .edid_byte(edid_byte), .edid_idx(edid_idx),
        .session_live(session_live), .session_port(session_port)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_ctrl = '0;
        foreach (m_d[i]) m_d[i] = '0;
        m_sel = 0; m_avail = 0; m_ptr = 0; m_port = 0;
    endtask

    task automatic m_apply(input logic [7:0] a, input logic [31:0] w);
        logic [31:0] r;
        logic [4:0]  len;
        logic [7:0]  b;
        case (a)
            8'h10: begin
                if (!w[31]) m_ctrl = w;
                else begin
                    r = m_d[0];
                    len = w[24:20];
                    m_ctrl = 32'h4000_0000 | ((r[28] ? 32'd2 : 32'd1) << 20);
                    if (len == 5'd3) begin
                        if (!r[30] || r[23:8] == 16'h0) begin
                            m_sel = 0; m_avail = 0; m_ptr = 0; m_port = 0;
                        end else if (r[23:8] == 16'h0050) begin
                            m_sel = 1; m_port = int'(port_id);
                            if (monitor_present[port_id]) m_avail = 1;
                        end
                        m_d[0] = 32'h0;
                    end else if (!r[28]) begin
                        m_d[0] = 32'h0;
                    end else if (len == 5'd4) begin
                        if (m_sel && m_avail) begin
                            if (m_ptr < 128) begin b = edid_at(m_ptr); m_ptr++; end
                            else b = 8'h00;
                        end else b = 8'hFF;
                        m_d[0] = {8'h00, b, 16'h0000};
                    end
                end
            end
            8'h14: m_d[0] = w;
            8'h18: m_d[1] = w;
            8'h1C: m_d[2] = w;
            8'h20: m_d[3] = w;
            8'h24: m_d[4] = w;
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = w;
        m_apply(a, w);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic check_all(input string tag);
        read_chk({tag, " ctrl"}, 8'h10, m_ctrl);
        read_chk({tag, " d1"}, 8'h14, m_d[0]);
        read_chk({tag, " d2"}, 8'h18, m_d[1]);
        read_chk({tag, " d3"}, 8'h1C, m_d[2]);
        read_chk({tag, " d4"}, 8'h20, m_d[3]);
        read_chk({tag, " d5"}, 8'h24, m_d[4]);
        read_chk({tag, " unmapped"}, 8'h28, 32'h0);
    endtask

    // Request helper: load data reg 1, then fire control with a length.
    task automatic request(input logic [31:0] rq, input logic [4:0] len);
        do_write(8'h14, rq);
        do_write(8'h10, 32'h8000_0000 | (32'(len) << 20));
    endtask

    // Every-clock comparison of session outputs against the model (R7).
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R7 edid_idx", 32'(edid_idx), 32'(m_ptr));
            check("R5 session_live", 32'(session_live), 32'(m_sel && m_avail));
            check("R5 session_port", 32'(session_port), 32'(m_port));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1 reset");
        // R2: data stores, unmapped offset ignored
        do_write(8'h18, 32'hA5A5_0001);
        do_write(8'h1C, 32'h1234_5678);
        do_write(8'h20, 32'hDEAD_BEEF);
        do_write(8'h24, 32'h0F0F_F0F0);
        do_write(8'h28, 32'hFFFF_FFFF);
        check_all("R2 data");
        // R3: control write without send bit
        do_write(8'h14, 32'h5000_5000);
        do_write(8'h10, 32'h0030_0000);
        check_all("R3 plain ctrl");
        // R8 + R4: read before any selection
        request(32'h5000_5000, 5'd4);
        check_all("R8 unselected read");
        // R5: select on port 1 with no monitor -> selected but not live
        port_id = 2'd1;
        request(32'h5000_5000, 5'd3);
        check_all("R5 no monitor");
        request(32'h5000_5000, 5'd4);
        check_all("R8 no monitor read");
        // R5: select on port 2 with a monitor
        port_id = 2'd2;
        request(32'h5000_5000, 5'd3);
        check_all("R5 select");
        // R7: several reads
        for (int i = 0; i < 4; i++) begin
            request(32'h5000_5000, 5'd4);
            read_chk("R7 read byte", 8'h14, m_d[0]);
        end
        check_all("R4 after reads");
        // R11: read with bad length
        request(32'h5000_5000, 5'd5);
        check_all("R11 bad read");
        // R10: write request with length 5
        request(32'h4000_5000, 5'd5);
        check_all("R10 write ack");
        // R12: foreign address leaves session
        request(32'h4000_3700, 5'd3);
        check_all("R12 foreign addr");
        request(32'h5000_5000, 5'd4);
        check_all("R12 read continues");
        // R6: stop
        request(32'h1000_5000, 5'd3);
        check_all("R6 stop");
        // R6: address 0 with MOT
        request(32'h5000_5000, 5'd3);
        request(32'h5000_5000, 5'd4);
        request(32'h4000_0000, 5'd3);
        check_all("R6 addr zero");
        // R9: saturation past 128
        request(32'h5000_5000, 5'd3);
        for (int i = 0; i < 131; i++) begin
            request(32'h5000_5000, 5'd4);
            read_chk(m_ptr >= 128 && i >= 128 ? "R9 saturated" : "R7 stream", 8'h14, m_d[0]);
        end
        check_all("R9 end");
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule